// File: doc/BRIEF.md
# Conditioned-Operand Arithmetic Logic Unit

This block is the arithmetic core of a small accumulator-style controller datapath. It takes two 8-bit operands and applies one of four core functions: bitwise AND, bitwise OR, bitwise XOR, or binary addition. Before that, each operand passes through its own conditioner. The carry-in for the addition comes from the block's own stored carry flag, which also passes through a conditioner. Each conditioner can leave its input unchanged, invert it, replace it with all zeros, or replace it with all ones.

With these few controls the one adder covers a wider set of operations:

- Subtraction is `A + ~B + 1`.
- Subtraction with borrow reverses the operands and feeds in the stored carry.
- Increment adds a forced-zero operand with a forced-one carry.
- Decrement adds an all-ones operand.
- Clear and set come from forcing the operands.
- Complement comes from inverting one operand and ORing it with zero.

The result and carry-out are combinational. The four condition flags are held in a register that updates on the clock edge, under a separate enable for each flag. The block has no data stream. Every pin is a plain control or status signal with no handshake, because the result is valid in the same cycle as its inputs.

Top module: `cond_alu8`

## Requirements
- R1: Each operand conditioner code `cond_a_i` / `cond_b_i` selects 00 = pass, 01 = bitwise invert, 10 = all zeros, 11 = all ones.
- R2: The addition carry-in is the stored carry flag (`flags_o[2]`) passed through the conditioner selected by `cond_c_i`. The codes are the same as in R1: pass, invert, force 0, force 1.
- R3: `op_i` selects 00 = AND, 01 = OR, 10 = XOR, 11 = ADD on the conditioned operands. `res_o` reflects the inputs in the same cycle.
- R4: `cout_o` is the carry out of bit 7 during ADD and is 0 during the logic functions.
- R5: `flags_o[0]` (negative) takes bit 7 of the result on a clock edge where `flag_we_i[0]` is 1.
- R6: `flags_o[1]` (zero) becomes 1 on a clock edge where `flag_we_i[1]` is 1 and all result bits are 0, and becomes 0 if any result bit is 1.
- R7: `flags_o[2]` (carry) takes `cout_o` on a clock edge where `flag_we_i[2]` is 1 and the function is ADD.
- R8: `flags_o[3]` (overflow) takes the XOR of the carries out of bits 7 and 6 on a clock edge where `flag_we_i[3]` is 1 and the function is ADD.
- R9: A flag whose enable bit is 0 keeps its value. The carry and overflow flags also keep their values during AND, OR and XOR, whatever their enables are.
- R10: An active-low asynchronous reset clears all four flags at once.
- R11: `A − B` is produced as invert-B with carry forced to 1, and sets the carry flag to 1 when no borrow occurs. `B − A − borrow` is produced as invert-A with the stored carry passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| cond_a_i | input | 2 | Conditioner code for operand A |
| cond_b_i | input | 2 | Conditioner code for operand B |
| cond_c_i | input | 2 | Conditioner code for the stored carry |
| op_i | input | 2 | Core function select |
| flag_we_i | input | 4 | Per-flag update enables: bit 0 = N, bit 1 = Z, bit 2 = C, bit 3 = V |
| res_o | output | 8 | Result |
| cout_o | output | 1 | Carry out of bit 7 (ADD only) |
| flags_o | output | 4 | Stored flags {V, C, Z, N} |

## Verification
The hardest case to reach from the ports is an addition whose carry-in passes through from the stored carry flag. In that case the expected result depends on an earlier operation. The bench first sets or clears the carry with a deliberate addition. It then runs the pass-through, inverted-carry and borrow-subtract cases. Its own flag model follows every enable. Overflow needs operands whose carries out of bits 6 and 7 differ, so the vectors include 7F+01 and 80+80.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
  typedef enum logic [1:0] {
    COND_PASS = 2'b00,
    COND_INV  = 2'b01,
    COND_ZERO = 2'b10,
    COND_ONE  = 2'b11
  } cond_e;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_XOR = 2'b10,
    OP_ADD = 2'b11
  } op_e;

  localparam int FLG_N = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_C = 2;
  localparam int FLG_V = 3;
  localparam int FLG_W = 4;
endpackage

// File: rtl/alu_conditioner.sv
module alu_conditioner #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] q_o
);
  import cond_alu_pkg::*;

  always_comb begin
    case (cond_e'(sel_i))
      COND_PASS: q_o = d_i;
      COND_INV:  q_o = ~d_i;
      COND_ZERO: q_o = '0;
      default:   q_o = '1;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  import cond_alu_pkg::*;

  localparam int LW = W - 1;

  logic [LW:0]  low_sum;
  logic         c_low;
  logic         c_top;
  logic         top_bit;
  logic [W-1:0] add_res;

  // low W-1 bits through one adder; its top bit is the carry out of bit W-2
  always_comb begin
    low_sum = {1'b0, a_i[LW-1:0]} + {1'b0, b_i[LW-1:0]} + {{LW{1'b0}}, cin_i};
    c_low   = low_sum[LW];
    top_bit = a_i[W-1] ^ b_i[W-1] ^ c_low;
    c_top   = (a_i[W-1] & b_i[W-1]) | (c_low & (a_i[W-1] ^ b_i[W-1]));
    add_res = {top_bit, low_sum[LW-1:0]};
  end

  always_comb begin
    cout_o = 1'b0;
    ovf_o  = 1'b0;
    case (op_e'(op_i))
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      default: begin
        res_o  = add_res;
        cout_o = c_top;
        ovf_o  = c_top ^ c_low;
      end
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [cond_alu_pkg::FLG_W-1:0] we_i,
  input  logic                          is_add_i,
  input  logic [W-1:0]                  res_i,
  input  logic                          cout_i,
  input  logic                          ovf_i,
  output logic [cond_alu_pkg::FLG_W-1:0] flags_o
);
  import cond_alu_pkg::*;

  logic [FLG_W-1:0] nxt;

  always_comb begin
    nxt = flags_o;
    if (we_i[FLG_N]) nxt[FLG_N] = res_i[W-1];
    if (we_i[FLG_Z]) nxt[FLG_Z] = (res_i == '0);
    if (is_add_i && we_i[FLG_C]) nxt[FLG_C] = cout_i;
    if (is_add_i && we_i[FLG_V]) nxt[FLG_V] = ovf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= nxt;
  end
endmodule

// File: rtl/cond_alu8.sv
module cond_alu8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   cond_a_i,
  input  logic [1:0]   cond_b_i,
  input  logic [1:0]   cond_c_i,
  input  logic [1:0]   op_i,
  input  logic [3:0]   flag_we_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic [3:0]   flags_o
);
  import cond_alu_pkg::*;

  localparam int NOPS = 2;

  logic [W-1:0] raw_op  [NOPS];
  logic [1:0]   raw_sel [NOPS];
  logic [W-1:0] cnd_op  [NOPS];
  logic         cin_c;
  logic         ovf;

  assign raw_op[0]  = a_i;
  assign raw_op[1]  = b_i;
  assign raw_sel[0] = cond_a_i;
  assign raw_sel[1] = cond_b_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_opc
    alu_conditioner #(.W(W)) u_cnd (
      .d_i  (raw_op[g]),
      .sel_i(raw_sel[g]),
      .q_o  (cnd_op[g])
    );
  end

  alu_conditioner #(.W(1)) u_cnd_c (
    .d_i  (flags_o[FLG_C]),
    .sel_i(cond_c_i),
    .q_o  (cin_c)
  );

  alu_core #(.W(W)) u_core (
    .a_i   (cnd_op[0]),
    .b_i   (cnd_op[1]),
    .cin_i (cin_c),
    .op_i  (op_i),
    .res_o (res_o),
    .cout_o(cout_o),
    .ovf_o (ovf)
  );

  alu_flag_reg #(.W(W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (flag_we_i),
    .is_add_i(op_i == OP_ADD),
    .res_i   (res_o),
    .cout_i  (cout_o),
    .ovf_i   (ovf),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/cond_alu8_chk.sv
module cond_alu8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   cond_a_i,
  input logic [1:0]   cond_b_i,
  input logic [1:0]   op_i,
  input logic [3:0]   flag_we_i,
  input logic [W-1:0] res_o,
  input logic         cout_o,
  input logic [3:0]   flags_o
);
  AST_AND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00 && cond_a_i == 2'b00 && cond_b_i == 2'b00) |-> res_o == (a_i & b_i)); // R3
  AST_NOT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b01 && cond_a_i == 2'b10 && cond_b_i == 2'b01) |-> res_o == ~b_i); // R1
  AST_LOGIC_NO_COUT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != 2'b11) |-> !cout_o); // R4
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i[0] |=> flags_o[0] == $past(res_o[W-1])); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i[1] |=> flags_o[1] == ($past(res_o) == '0)); // R6
  AST_CARRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i[2] && op_i == 2'b11) |=> flags_o[2] == $past(cout_o)); // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i == 4'b0000) |=> $stable(flags_o)); // R9
  AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != 2'b11) |=> $stable(flags_o[3:2])); // R9
endmodule

bind cond_alu8 cond_alu8_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_i      (a_i),
  .b_i      (b_i),
  .cond_a_i (cond_a_i),
  .cond_b_i (cond_b_i),
  .op_i     (op_i),
  .flag_we_i(flag_we_i),
  .res_o    (res_o),
  .cout_o   (cout_o),
  .flags_o  (flags_o)
);

// File: tb/sim_cond_alu8.sv
`timescale 1ns/100ps
module sim_cond_alu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a, b;
  logic [1:0] ca, cb, cc, op;
  logic [3:0] we;
  logic [7:0] res;
  logic       cout;
  logic [3:0] flags;
  logic [3:0] exp_flags;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cond_alu8 u0 (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b),
    .cond_a_i(ca), .cond_b_i(cb), .cond_c_i(cc), .op_i(op),
    .flag_we_i(we), .res_o(res), .cout_o(cout), .flags_o(flags)
  );

  // {a, b, ca, cb, cc, op, exp_res, exp_cout, exp_v}
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {8'h3C, 8'h0F, 2'd0, 2'd0, 2'd2, 2'd0, 8'h0C, 1'b0, 1'b0}, // R3 AND
    {8'h3C, 8'h0F, 2'd0, 2'd0, 2'd2, 2'd1, 8'h3F, 1'b0, 1'b0}, // R3 OR
    {8'h3C, 8'h0F, 2'd0, 2'd0, 2'd2, 2'd2, 8'h33, 1'b0, 1'b0}, // R3 XOR
    {8'h3C, 8'h0F, 2'd0, 2'd0, 2'd2, 2'd3, 8'h4B, 1'b0, 1'b0}, // R3 ADD
    {8'h3C, 8'h0F, 2'd0, 2'd1, 2'd3, 2'd3, 8'h2D, 1'b1, 1'b0}, // R11 A-B
    {8'h0F, 8'h3C, 2'd0, 2'd1, 2'd3, 2'd3, 8'hD3, 1'b0, 1'b0}, // R11 borrow
    {8'hFF, 8'h01, 2'd0, 2'd0, 2'd2, 2'd3, 8'h00, 1'b1, 1'b0}, // R4 carry
    {8'h7F, 8'h01, 2'd0, 2'd0, 2'd2, 2'd3, 8'h80, 1'b0, 1'b1}, // R8 overflow
    {8'h55, 8'h00, 2'd1, 2'd2, 2'd2, 2'd1, 8'hAA, 1'b0, 1'b0}, // R1 invert
    {8'h12, 8'h34, 2'd2, 2'd2, 2'd2, 2'd3, 8'h00, 1'b0, 1'b0}, // R1 zeros
    {8'h12, 8'h34, 2'd3, 2'd2, 2'd2, 2'd1, 8'hFF, 1'b0, 1'b0}, // R1 ones
    {8'h41, 8'h00, 2'd0, 2'd2, 2'd3, 2'd3, 8'h42, 1'b0, 1'b0}, // R2 force 1
    {8'h00, 8'h00, 2'd0, 2'd3, 2'd2, 2'd3, 8'hFF, 1'b0, 1'b0}, // R1 decrement
    {8'h80, 8'h80, 2'd0, 2'd0, 2'd2, 2'd3, 8'h00, 1'b1, 1'b1}, // R8 overflow
    {8'hA5, 8'h5A, 2'd3, 2'd1, 2'd2, 2'd0, 8'hA5, 1'b0, 1'b0}  // R1 mixed
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] ia, ib, input logic [1:0] ica, icb, icc, iop,
                     input logic [3:0] iwe, input logic [7:0] xr, input logic xc, xv,
                     input string req);
    @(negedge clk);
    a = ia; b = ib; ca = ica; cb = icb; cc = icc; op = iop; we = iwe;
    #1;
    chk({req, " result"}, res, xr);
    chk({req, " R4 cout"}, {7'd0, cout}, {7'd0, xc});
    if (iwe[0]) exp_flags[0] = xr[7];
    if (iwe[1]) exp_flags[1] = (xr == 8'h00);
    if (iop == 2'd3 && iwe[2]) exp_flags[2] = xc;
    if (iop == 2'd3 && iwe[3]) exp_flags[3] = xv;
    @(posedge clk); #1;
    chk({req, " flags R5 R6 R7 R8 R9"}, {4'd0, flags}, {4'd0, exp_flags});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a = 0; b = 0; ca = 0; cb = 0; cc = 0; op = 0; we = 0;
    exp_flags = 4'h0;
    #12;
    chk("R10 reset flags", {4'd0, flags}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][33:26], VEC[i][25:18], VEC[i][17:16], VEC[i][15:14], VEC[i][13:12],
          VEC[i][11:10], 4'hF, VEC[i][9:2], VEC[i][1], VEC[i][0], "vector");
    end
    // C=1 left by 80+80; pass the stored carry into an add (R2)
    run(8'h10, 8'h20, 2'd0, 2'd0, 2'd0, 2'd3, 4'hF, 8'h31, 1'b0, 1'b0, "R2 pass carry");
    // C now 0; inverted carry gives 1 (R2)
    run(8'h10, 8'h20, 2'd0, 2'd0, 2'd1, 2'd3, 4'hF, 8'h31, 1'b0, 1'b0, "R2 invert carry");
    run(8'hFF, 8'h01, 2'd0, 2'd0, 2'd2, 2'd3, 4'hF, 8'h00, 1'b1, 1'b0, "R7 set carry");
    // B - A with stored carry as no-borrow (R11)
    run(8'h10, 8'h30, 2'd1, 2'd0, 2'd0, 2'd3, 4'hF, 8'h20, 1'b1, 1'b0, "R11 B-A");
    // enables off: flags hold (R9)
    run(8'h00, 8'h00, 2'd0, 2'd0, 2'd2, 2'd3, 4'h0, 8'h00, 1'b0, 1'b0, "R9 hold");
    // logic op with all enables: C and V keep (R9)
    run(8'h81, 8'h00, 2'd0, 2'd0, 2'd2, 2'd2, 4'hF, 8'h81, 1'b0, 1'b0, "R9 logic keeps CV");
    // only N enabled (R5, R9)
    run(8'h00, 8'h00, 2'd0, 2'd0, 2'd2, 2'd3, 4'h1, 8'h00, 1'b0, 1'b0, "R5 N only");
    // asynchronous reset between edges (R10)
    @(negedge clk); #1;
    rst_n = 1'b0; #0.5;
    chk("R10 async clear", {4'd0, flags}, 8'h00);
    #2; rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule